// File: doc/BRIEF.md
# Sync-Hunting Serial Frame Deframer

This block sits behind a bit-level demodulator that hands over received line data one byte at a time. Inside each line byte the earliest bit on the air sits in bit 0. The deframer treats the traffic as one continuous bit stream and searches it for a 16-bit sync pattern. That pattern may start at any bit, so it can straddle line bytes at any of the eight possible alignments. When the pattern is found, the deframer re-cuts every following bit into frame bytes, with the earliest bit as the most significant. It writes the frame into an external buffer through a single write port: the two sync bytes first, then the length byte, the payload and two check bytes.

After the last check byte the block raises a done flag and stops taking data until it is restarted. It reports the total frame size and whether the frame check passed. The check is a 16-bit CRC taken over everything after the sync bytes. Line bytes must arrive with at least one idle cycle between them, which holds easily for any serial source clocked well below the core clock.

Top module: `sync_deframer`

## Requirements
- R1: The sync pattern is 0xB24D in the re-cut, most-significant-first bit order. It is found at every bit offset. The buffer then receives 0xB2 at address 0, 0x4D at address 1, and each later frame byte at the next address, with bits realigned across line-byte boundaries.
- R2: Line bytes equal to zero never cause a write. A bit sequence that is broken up by zero line bytes does not synchronise.
- R3: When the sync pattern ends exactly on a line-byte boundary, the next line byte, bit-reversed, is stored whole at address 2 as the length byte.
- R4: For a length byte L with 1 ≤ L ≤ 255, the block takes L−1 payload bytes (none when L is 1) and then exactly two check bytes. It writes L+4 bytes in all and reports frame_len = L+4 from the cycle after the length byte is written.
- R5: crc_ok is 1 exactly when the CRC over buffer addresses 2 through L+3 is zero. The CRC is CRC-16 with polynomial 0x1021 and initial value 0x0000, taken most-significant bit first. crc_ok is never 1 while frame_done is 0.
- R6: frame_done rises in the cycle after the edge that takes the last check byte. It stays high until restart. Line bytes that arrive while it is high cause no write and change no output.
- R7: A restart returns the block to hunting in the next cycle, with frame_done, crc_ok and frame_len at 0. Any frame in progress is dropped, and a following frame is received normally.
- R8: After reset, wr_en, frame_done, crc_ok and frame_len are all 0.
- R9: No write goes to an address at or above BUF_DEPTH. A frame that would need such a write is abandoned without frame_done, and the block goes back to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Drop the current frame and resume hunting |
| byte_valid | input | 1 | line_byte holds a new line byte this cycle |
| line_byte | input | 8 | Eight line bits, earliest in bit 0 |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(BUF_DEPTH+1) | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| frame_len | output | 9 | Total frame size in bytes, sync and check included |
| frame_done | output | 1 | Frame complete; input ignored until restart |
| crc_ok | output | 1 | Frame check residue was zero |

## Verification
A wrong sync offset or packer shift shows up in the buffer contents on the first write after address 1, one cycle after the line byte that completes it. A miscounted length or data counter shows up at the end of the frame. There, frame_done is early, late or missing, and the write count differs from L+4 within one line byte of the true end. A CRC fault affects only crc_ok, so the frame check is driven with both intact and corrupted check bytes. A restart or overflow fault is visible in the cycle after the event, either as a write that should not happen or as a following frame that never completes.

// File: rtl/deframer_pkg.sv
// deframer_pkg: constants, state encoding and helpers shared by the deframer.
// Assumes line bytes carry the earliest bit in bit 0.
package deframer_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = 4;
    localparam logic [15:0] SYNC_WORD = 16'hB24D;
    localparam logic [15:0] CRC_POLY  = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_LEN,
        ST_DATA,
        ST_CHK,
        ST_FULL
    } dfr_state_e;

    // Turn a line byte into most-significant-first order.
    function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/dfr_sync_hunter.sv
// dfr_sync_hunter: shifts one reordered byte through the 16-bit history, one
// bit at a time, and reports the first bit position (1..8) at which the
// history equals the sync word. Purely combinational.
module dfr_sync_hunter
    import deframer_pkg::*;
(
    input  logic [15:0]       sr_in,
    input  logic [BYTE_W-1:0] msb_byte,
    output logic [15:0]       sr_out,
    output logic              hit,
    output logic [POS_W-1:0]  hit_pos
);
    logic [15:0] stage [0:BYTE_W];

    assign stage[0] = sr_in;

    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_bit
        assign stage[gi+1] = {stage[gi][14:0], msb_byte[BYTE_W-1-gi]};
    end

    assign sr_out = stage[BYTE_W];

    // Earliest matching bit position wins.
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int i = BYTE_W; i >= 1; i--) begin
            if (stage[i] == SYNC_WORD) begin
                hit     = 1'b1;
                hit_pos = POS_W'(i);
            end
        end
    end
endmodule

// File: rtl/dfr_byte_packer.sv
// dfr_byte_packer: joins the leftover bits of the previous line byte with the
// head of the current one. offs (1..8) is how many bits of the current byte
// complete the output byte; 8 means the stream is byte aligned.
module dfr_byte_packer
    import deframer_pkg::*;
(
    input  logic [BYTE_W-1:0] part,
    input  logic [BYTE_W-1:0] msb_byte,
    input  logic [POS_W-1:0]  offs,
    output logic [BYTE_W-1:0] packed_byte
);
    logic [2*BYTE_W-1:0] joined;

    // Take the byte that ends offs bits into the current line byte.
    always_comb begin
        joined      = {part, msb_byte} >> (POS_W'(BYTE_W) - offs);
        packed_byte = joined[BYTE_W-1:0];
    end
endmodule

// File: rtl/dfr_crc16.sv
// dfr_crc16: one-byte step of a 16-bit CRC, most significant bit first.
// Purely combinational; the caller holds the running value.
module dfr_crc16
    import deframer_pkg::*;
(
    input  logic [15:0]       crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [15:0]       crc_out
);
    logic [15:0] c [0:BYTE_W];

    assign c[0] = crc_in;

    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_step
        assign c[gi+1] = {c[gi][14:0], 1'b0}
                       ^ ((c[gi][15] ^ data[BYTE_W-1-gi]) ? CRC_POLY : 16'h0000);
    end

    assign crc_out = c[BYTE_W];
endmodule

// File: rtl/sync_deframer.sv
// sync_deframer: hunts a received line-byte stream for the sync word at any
// bit offset, then realigns and stores length, payload and check bytes into an
// external buffer, flags completion and the CRC result.
// Assumes byte_valid is never high on two consecutive cycles.
module sync_deframer
    import deframer_pkg::*;
#(
    parameter int BUF_DEPTH = 260,
    localparam int AW = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] line_byte,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [8:0]        frame_len,
    output logic              frame_done,
    output logic              crc_ok
);
    dfr_state_e        state;
    logic [15:0]       sr, sr_h;
    logic [BYTE_W-1:0] part, msb, packed_byte;
    logic [POS_W-1:0]  offs, hit_pos;
    logic [AW-1:0]     ptr;
    logic [7:0]        rem;
    logic              chk_hi, sync_pend, hit;
    logic [15:0]       crc, crc_nx;
    logic              room;

    assign msb  = rev8(line_byte);
    assign room = ptr < AW'(BUF_DEPTH);

    dfr_sync_hunter u_hunt (
        .sr_in(sr), .msb_byte(msb), .sr_out(sr_h), .hit(hit), .hit_pos(hit_pos)
    );

    dfr_byte_packer u_pack (
        .part(part), .msb_byte(msb), .offs(offs), .packed_byte(packed_byte)
    );

    dfr_crc16 u_crc (
        .crc_in(crc), .data(packed_byte), .crc_out(crc_nx)
    );

    // Frame state machine, buffer write port and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sr         <= '0;
            part       <= '0;
            offs       <= POS_W'(BYTE_W);
            ptr        <= '0;
            rem        <= '0;
            chk_hi     <= 1'b0;
            sync_pend  <= 1'b0;
            crc        <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            frame_len  <= '0;
            frame_done <= 1'b0;
            crc_ok     <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (restart) begin
                state      <= ST_IDLE;
                sync_pend  <= 1'b0;
                frame_len  <= '0;
                frame_done <= 1'b0;
                crc_ok     <= 1'b0;
            end else begin
                if (sync_pend) begin
                    sync_pend <= 1'b0;
                    wr_en     <= 1'b1;
                    wr_addr   <= AW'(1);
                    wr_data   <= SYNC_WORD[7:0];
                end
                if (byte_valid) begin
                    unique case (state)
                        ST_IDLE: begin
                            if (line_byte != '0) begin
                                sr    <= {8'h00, msb};
                                state <= ST_HUNT;
                            end
                        end
                        ST_HUNT: begin
                            if (line_byte == '0) begin
                                state <= ST_IDLE;
                            end else begin
                                sr <= sr_h;
                                if (hit) begin
                                    state     <= ST_LEN;
                                    offs      <= hit_pos;
                                    part      <= msb;
                                    ptr       <= AW'(2);
                                    crc       <= '0;
                                    frame_len <= '0;
                                    wr_en     <= 1'b1;
                                    wr_addr   <= '0;
                                    wr_data   <= SYNC_WORD[15:8];
                                    sync_pend <= 1'b1;
                                end
                            end
                        end
                        ST_LEN, ST_DATA, ST_CHK: begin
                            if (!room) begin
                                state <= ST_IDLE;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= packed_byte;
                                part    <= msb;
                                ptr     <= ptr + AW'(1);
                                crc     <= crc_nx;
                                if (state == ST_LEN) begin
                                    frame_len <= 9'(packed_byte) + 9'd4;
                                    chk_hi    <= 1'b0;
                                    if (packed_byte <= 8'd1) begin
                                        state <= ST_CHK;
                                    end else begin
                                        state <= ST_DATA;
                                        rem   <= packed_byte - 8'd1;
                                    end
                                end else if (state == ST_DATA) begin
                                    rem <= rem - 8'd1;
                                    if (rem == 8'd1) state <= ST_CHK;
                                end else begin
                                    chk_hi <= 1'b1;
                                    if (chk_hi) begin
                                        state      <= ST_FULL;
                                        frame_done <= 1'b1;
                                        crc_ok     <= (crc_nx == 16'h0000);
                                    end
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // input assumption: line bytes are separated by idle cycles
    byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R1
    sync_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && !restart) |=> (wr_en && wr_addr == AW'(1) && wr_data == 8'h4D));

    // R5
    crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> frame_done);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !restart) |=> frame_done);

    // R6
    full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !wr_en);

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!frame_done && !crc_ok && frame_len == '0));

    // R9
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < AW'(BUF_DEPTH)));
endmodule

// File: tb/tb_sync_deframer.sv
module tb_sync_deframer;
    localparam int DEPTH = 260;
    localparam int SMALL = 16;
    localparam int AW  = $clog2(DEPTH + 1);
    localparam int SAW = $clog2(SMALL + 1);
    localparam int NV  = 6;
    // offset bits, length byte, corrupt, seed
    localparam int VEC [NV][4] = '{
        '{0, 6,   0, 17},
        '{3, 10,  0, 40},
        '{7, 2,   0, 99},
        '{5, 20,  1, 3},
        '{1, 1,   0, 8},
        '{4, 255, 0, 61}
    };

    logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, byte_valid = 1'b0;
    logic [7:0] line_byte = 8'h00;
    logic wr_en, frame_done, crc_ok, s_wr_en, s_done, s_crc_ok;
    logic [AW-1:0] wr_addr;
    logic [SAW-1:0] s_wr_addr;
    logic [7:0] wr_data, s_wr_data;
    logic [8:0] frame_len, s_len;

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, s_wr_cnt = 0, s_max_addr = -1;
    logic [7:0] cap [0:DEPTH-1];
    logic [7:0] fr [0:DEPTH+3];
    bit sb [0:4095];
    int nb_line;
    bit finished = 0;

    always #10 clk = ~clk;

    sync_deframer #(.BUF_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .byte_valid(byte_valid),
        .line_byte(line_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_len(frame_len), .frame_done(frame_done), .crc_ok(crc_ok));

    sync_deframer #(.BUF_DEPTH(SMALL)) dut_small (
        .clk(clk), .rst_n(rst_n), .restart(restart), .byte_valid(byte_valid),
        .line_byte(line_byte), .wr_en(s_wr_en), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
        .frame_len(s_len), .frame_done(s_done), .crc_ok(s_crc_ok));

    always @(negedge clk) begin
        if (wr_en) begin
            cap[wr_addr] = wr_data;
            wr_cnt++;
        end
        if (s_wr_en) begin
            s_wr_cnt++;
            if (int'(s_wr_addr) > s_max_addr) s_max_addr = int'(s_wr_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c = c_in;
        for (int i = 7; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic build(input int s, input int len, input bit bad, input int seed);
        logic [15:0] c = 16'h0000;
        int n = len + 4;
        fr[0] = 8'hB2;
        fr[1] = 8'h4D;
        fr[2] = 8'(len);
        for (int i = 0; i < len - 1; i++) fr[3+i] = 8'(seed + 13 * i);
        for (int i = 2; i <= len + 1; i++) c = crc_upd(c, fr[i]);
        fr[len+2] = c[15:8];
        fr[len+3] = c[7:0] ^ (bad ? 8'h01 : 8'h00);
        for (int i = 0; i < 4096; i++) sb[i] = 1'b0;
        for (int i = 0; i < n * 8; i++) sb[16+s+i] = fr[i/8][7-(i%8)];
        nb_line = (16 + s + n * 8 + 7) / 8;
    endtask

    task automatic send_line(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        line_byte  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        line_byte  = 8'h00;
    endtask

    task automatic send_stream(input int count);
        for (int i = 0; i < count; i++) begin
            logic [7:0] b;
            for (int j = 0; j < 8; j++) b[j] = sb[8*i+j];
            send_line(b);
        end
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        wr_cnt = 0;
        s_wr_cnt = 0;
        s_max_addr = -1;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(!wr_en && !frame_done && !crc_ok && frame_len == 0, "R8",
            int'({wr_en, frame_done, crc_ok}) + int'(frame_len), 0);

        // Vector table walk: R1 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            int s = VEC[v][0], len = VEC[v][1], seed = VEC[v][3];
            bit bad = VEC[v][2] != 0;
            int miss = 0, first_miss = -1;
            do_restart();
            build(s, len, bad, seed);
            send_stream(nb_line);
            repeat (2) @(negedge clk);
            chk(frame_done == 1'b1, "R6 done after last check byte", int'(frame_done), 1);
            chk(crc_ok == !bad, "R5 crc result", int'(crc_ok), int'(!bad));
            chk(int'(frame_len) == len + 4, "R4 frame_len", int'(frame_len), len + 4);
            chk(wr_cnt == len + 4, "R4 write count", wr_cnt, len + 4);
            for (int i = 0; i < len + 4; i++) begin
                if (cap[i] !== fr[i]) begin
                    miss++;
                    if (first_miss < 0) first_miss = i;
                end
            end
            if (s == 0) chk(cap[2] == 8'(len), "R3 aligned length byte", int'(cap[2]), len);
            chk(miss == 0, "R1 realigned contents (mismatches)", miss, 0);
            // R6 a byte after completion is ignored
            send_line(8'hA5);
            repeat (2) @(negedge clk);
            chk(wr_cnt == len + 4 && frame_done, "R6 ignored after done", wr_cnt, len + 4);
            // R9 small buffer instance
            if (len + 4 > SMALL) begin
                chk(!s_done, "R9 overflow abandons frame", int'(s_done), 0);
                chk(s_max_addr == SMALL - 1, "R9 highest address", s_max_addr, SMALL - 1);
            end else begin
                chk(s_done && s_crc_ok == !bad, "R9 fitting frame completes", int'(s_done), 1);
            end
            // R7 restart clears flags
            do_restart();
            @(negedge clk);
            chk(!frame_done && !crc_ok && frame_len == 0, "R7 restart clears",
                int'({frame_done, crc_ok}) + int'(frame_len), 0);
        end

        // R2 near-sync broken by zero bytes: no write
        do_restart();
        send_line(8'h00);
        send_line(8'h4D);
        send_line(8'h00);
        send_line(8'hB2);
        send_line(8'h00);
        send_line(8'h00);
        repeat (2) @(negedge clk);
        chk(wr_cnt == 0, "R2 zero bytes and broken sync", wr_cnt, 0);

        // R7 restart mid-frame, then a full frame is received
        do_restart();
        build(2, 12, 1'b0, 77);
        send_stream(6);
        do_restart();
        repeat (2) @(negedge clk);
        chk(wr_cnt == 0 && !frame_done, "R7 mid-frame restart quiet", wr_cnt, 0);
        send_stream(nb_line);
        repeat (2) @(negedge clk);
        chk(frame_done && crc_ok && wr_cnt == 16, "R7 frame after restart", wr_cnt, 16);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule